// File: doc/BRIEF.md
# Parallel Port Device Control Register

This block is the 8-bit control register of an extended-capability parallel port. The CPU reaches it over a small register bus made of a select (the address decode hit), a write strobe, write data and read data. The stored bits drive four printer control pins, each with a fixed polarity. They also hold a transfer direction bit, which the current port mode can override, and an interrupt enable for the acknowledge line.

The acknowledge input comes from the cable and is asynchronous. It passes through a two-flop synchronizer and an edge stage. When the interrupt enable is set, a low-to-high transition raises an interrupt request. The request stays up until the CPU reads the port's status register, which is signalled by a one-cycle strobe, or until software clears the enable.

Top module: `pport_ctrl_reg`

## Requirements
- R1: After a synchronous reset, all six writable bits are 0, a read returns 0xC0, the strobe, auto-feed and select-in pins are 1, the init pin is 0, the direction output is 0 (output) and the interrupt request is 0.
- R2: Read bits 7 and 6 always return 1, whatever was written to them.
- R3: Read bits 5..0 return the value last written, whatever the port mode is. When the register is not selected, the read data is 0x00.
- R4: The strobe pin is the inverse of bit 0 and the auto-feed pin is the inverse of bit 1. Both take the new value in the cycle after the write edge.
- R5: The init pin equals bit 2 and the select-in pin is the inverse of bit 3.
- R6: The direction output (1 = input) equals bit 5, except that it is 0 whenever port_mode is 3'b000 or 3'b010. It follows port_mode combinationally.
- R7: With bit 4 set, a rise on ack_in is seen on irq after the third rising clock edge that follows the change. A falling or steady ack_in raises nothing.
- R8: Once raised, irq holds until a cycle with status_rd high, and drops at that edge. An acknowledge rise that reaches the edge stage in the same cycle keeps irq high.
- R9: Writing 0 to bit 4 drops irq at that write edge. An acknowledge rise that reaches the edge stage while bit 4 is 0 is lost.
- R10: The register changes only on an edge where reg_sel and reg_wr are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Address decode hit for this register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, 0 when not selected |
| status_rd | input | 1 | One-cycle pulse when the status register is read |
| port_mode | input | 3 | Current port operating mode |
| ack_in | input | 1 | Asynchronous acknowledge from the peripheral |
| strobe_pin | output | 1 | Strobe control pin (inverse of bit 0) |
| autofd_pin | output | 1 | Auto-feed control pin (inverse of bit 1) |
| init_pin | output | 1 | Initialize control pin (equals bit 2) |
| selin_pin | output | 1 | Select-in control pin (inverse of bit 3) |
| dir_is_input | output | 1 | Effective direction, 1 = input |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted stored bit shows up one cycle later on a pin or in the read data, because every pin and read bit is a plain function of the register. A corrupt synchronizer or edge stage shows up as an interrupt that comes one cycle early or late, appears on a falling edge, or fires while disabled. The bench models the three-edge latency exactly, so a timing slip of one cycle fails at once. A stuck request flag shows up as irq outliving a status read or a cleared enable by one cycle.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int REG_W   = 8;
    localparam int CTL_W   = 6;
    localparam int MODE_W  = 3;
    localparam logic [REG_W-CTL_W-1:0] FIXED_HI = '1;

    typedef logic [MODE_W-1:0] mode_t;
    localparam mode_t MODE_COMPAT = 3'b000;
    localparam mode_t MODE_CFIFO  = 3'b010;

    // Stored control bits; field order is the bit order the CPU sees.
    typedef struct packed {
        logic dir_in;
        logic irq_en;
        logic sel_in;
        logic init;
        logic auto_fd;
        logic strobe;
    } ctl_t;

    typedef struct packed {
        logic strobe_pin;
        logic autofd_pin;
        logic init_pin;
        logic selin_pin;
    } pins_t;

    function automatic pins_t map_pins(ctl_t c);
        pins_t p;
        p.strobe_pin = ~c.strobe;
        p.autofd_pin = ~c.auto_fd;
        p.init_pin   =  c.init;
        p.selin_pin  = ~c.sel_in;
        return p;
    endfunction

    function automatic logic mode_forces_out(mode_t m);
        return (m == MODE_COMPAT) || (m == MODE_CFIFO);
    endfunction

endpackage

// File: rtl/pport_ack_sync.sv
module pport_ack_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_in,
    output logic ack_rise
);
    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LAST-1:0], ack_in};
    end

    assign ack_rise = chain[LAST-1] & ~chain[LAST];
endmodule

// File: rtl/pport_ctl_store.sv
module pport_ctl_store
    import pport_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl_q,
    output ctl_t             ctl_d
);
    always_comb begin
        ctl_d = wr_en ? ctl_t'(wdata) : ctl_q;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end
endmodule

// File: rtl/pport_irq_gen.sv
module pport_irq_gen (
    input  logic clk,
    input  logic rst,
    input  logic en_next,
    input  logic ack_rise,
    input  logic status_rd,
    output logic irq
);
    logic irq_d;

    always_comb begin
        irq_d = en_next & (ack_rise | (irq & ~status_rd));
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= irq_d;
    end
endmodule

// File: rtl/pport_ctrl_reg.sv
module pport_ctrl_reg
    import pport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             status_rd,
    input  logic [MODE_W-1:0] port_mode,
    input  logic             ack_in,
    output logic             strobe_pin,
    output logic             autofd_pin,
    output logic             init_pin,
    output logic             selin_pin,
    output logic             dir_is_input,
    output logic             irq
);
    ctl_t  ctl_q;
    ctl_t  ctl_d;
    pins_t pins;
    logic  wr_en;
    logic  ack_rise;
    logic  unused_wr_hi;

    assign wr_en        = reg_sel & reg_wr;
    assign unused_wr_hi = ^reg_wdata[REG_W-1:CTL_W];

    pport_ctl_store u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .wdata (reg_wdata[CTL_W-1:0]),
        .ctl_q (ctl_q),
        .ctl_d (ctl_d)
    );

    pport_ack_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .ack_in   (ack_in),
        .ack_rise (ack_rise)
    );

    pport_irq_gen u_irq (
        .clk       (clk),
        .rst       (rst),
        .en_next   (ctl_d.irq_en),
        .ack_rise  (ack_rise),
        .status_rd (status_rd),
        .irq       (irq)
    );

    always_comb begin
        pins         = map_pins(ctl_q);
        strobe_pin   = pins.strobe_pin;
        autofd_pin   = pins.autofd_pin;
        init_pin     = pins.init_pin;
        selin_pin    = pins.selin_pin;
        dir_is_input = ctl_q.dir_in & ~mode_forces_out(mode_t'(port_mode));
        reg_rdata    = reg_sel ? {FIXED_HI, ctl_q} : '0;
    end
endmodule

// File: rtl/pport_ctrl_chk.sv
module pport_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_sel,
    input logic       reg_wr,
    input logic       wd_strobe,
    input logic       wd_irq_en,
    input logic [7:0] reg_rdata,
    input logic       status_rd,
    input logic [2:0] port_mode,
    input logic       ack_in,
    input logic       strobe_pin,
    input logic       dir_is_input,
    input logic       irq
);
    logic en_shadow;

    always_ff @(posedge clk) begin
        if (rst)                    en_shadow <= 1'b0;
        else if (reg_sel && reg_wr) en_shadow <= wd_irq_en;
    end

    AST_HI_BITS_ONE: assert property (@(posedge clk) disable iff (rst)
        reg_sel |-> reg_rdata[7:6] == 2'b11); // R2

    AST_MODE_FORCES_OUT: assert property (@(posedge clk) disable iff (rst)
        (port_mode == 3'b000 || port_mode == 3'b010) |-> !dir_is_input); // R6

    AST_STROBE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_wr) |=> strobe_pin == !$past(wd_strobe)); // R4

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq |-> en_shadow); // R9

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (irq && !status_rd && !(reg_sel && reg_wr && !wd_irq_en)) |=> irq); // R8

    AST_IRQ_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(ack_in, 3)); // R7
endmodule

bind pport_ctrl_reg pport_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_sel      (reg_sel),
    .reg_wr       (reg_wr),
    .wd_strobe    (reg_wdata[0]),
    .wd_irq_en    (reg_wdata[4]),
    .reg_rdata    (reg_rdata),
    .status_rd    (status_rd),
    .port_mode    (port_mode),
    .ack_in       (ack_in),
    .strobe_pin   (strobe_pin),
    .dir_is_input (dir_is_input),
    .irq          (irq)
);

// File: tb/sim_pport_ctrl_reg.sv
module sim_pport_ctrl_reg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       status_rd = 1'b0;
    logic [2:0] port_mode = 3'b000;
    logic       ack_in = 1'b0;
    logic       strobe_pin, autofd_pin, init_pin, selin_pin, dir_is_input, irq;

    int tests = 0;
    int fails = 0;

    // Bench model
    logic [5:0] m_reg = 6'h00;
    logic       m_irq = 1'b0;
    logic       q1 = 1'b0, q2 = 1'b0, q3 = 1'b0;

    always #2 clk = ~clk;

    pport_ctrl_reg u0 (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status_rd(status_rd),
        .port_mode(port_mode), .ack_in(ack_in), .strobe_pin(strobe_pin),
        .autofd_pin(autofd_pin), .init_pin(init_pin), .selin_pin(selin_pin),
        .dir_is_input(dir_is_input), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_dir(logic [5:0] r, logic [2:0] m);
        return r[5] && !(m == 3'b000 || m == 3'b010);
    endfunction

    task automatic check_all(input string irq_tag);
        chk("R3 low read bits", {2'b00, reg_rdata[5:0]}, reg_sel ? {2'b00, m_reg} : 8'h00);
        chk("R2 high read bits", {6'b0, reg_rdata[7:6]}, reg_sel ? 8'h03 : 8'h00);
        chk("R4 strobe/autofd", {6'b0, strobe_pin, autofd_pin}, {6'b0, ~m_reg[0], ~m_reg[1]});
        chk("R5 init/selin", {6'b0, init_pin, selin_pin}, {6'b0, m_reg[2], ~m_reg[3]});
        chk("R6 direction", {7'b0, dir_is_input}, {7'b0, exp_dir(m_reg, port_mode)});
        chk(irq_tag, {7'b0, irq}, {7'b0, m_irq});
    endtask

    // Drive one cycle at a negedge, advance to the next negedge, check.
    task automatic step(input logic s, input logic w, input logic [7:0] d,
                        input logic [2:0] m, input logic a, input logic sr,
                        input string irq_tag);
        logic en_next, rise;
        reg_sel = s; reg_wr = w; reg_wdata = d; port_mode = m;
        ack_in = a; status_rd = sr;
        en_next = (s && w) ? d[4] : m_reg[4];
        rise    = q2 && !q3;
        @(negedge clk);
        if (s && w) m_reg = d[5:0];
        m_irq = en_next && (rise || (m_irq && !sr));
        q3 = q2; q2 = q1; q1 = a;
        check_all(irq_tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        reg_sel = 1'b1;
        #1;
        // R1 reset state
        chk("R1 read", reg_rdata, 8'hC0);
        chk("R1 pins", {4'b0, strobe_pin, autofd_pin, init_pin, selin_pin}, 8'b0000_1101);
        chk("R1 dir", {7'b0, dir_is_input}, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);

        // R10 no write without both strobes
        step(0, 1, 8'h3F, 3'b001, 0, 0, "R7");
        step(1, 0, 8'h3F, 3'b001, 0, 0, "R7");
        chk("R10 unchanged", reg_rdata, 8'hC0);
        // R2 writes to upper bits ignored
        step(1, 1, 8'h00, 3'b001, 0, 0, "R7");
        chk("R2 write 00", reg_rdata, 8'hC0);
        step(1, 1, 8'hFF, 3'b001, 0, 0, "R7");
        chk("R3 write FF", reg_rdata, 8'hFF);
        step(1, 1, 8'h0A, 3'b001, 0, 0, "R7");
        chk("R4 strobe after 0A", {7'b0, strobe_pin}, 8'h01);
        chk("R5 selin after 0A", {7'b0, selin_pin}, 8'h00);

        // R6 mode sweep with direction bit set
        step(1, 1, 8'h20, 3'b001, 0, 0, "R7");
        for (int k = 0; k < 8; k++) begin
            step(1, 0, 8'h00, 3'(k), 0, 0, "R7");
            chk("R6 sweep", {7'b0, dir_is_input},
                {7'b0, (k != 0 && k != 2) ? 1'b1 : 1'b0});
            chk("R3 readback with mode", reg_rdata, 8'hE0);
        end

        // R7 latency
        step(1, 1, 8'h10, 3'b011, 0, 0, "R7");
        step(0, 0, 8'h00, 3'b011, 0, 0, "R7");
        step(0, 0, 8'h00, 3'b011, 1, 0, "R7");
        chk("R7 after 1 edge", {7'b0, irq}, 8'h00);
        step(0, 0, 8'h00, 3'b011, 1, 0, "R7");
        chk("R7 after 2 edges", {7'b0, irq}, 8'h00);
        step(0, 0, 8'h00, 3'b011, 1, 0, "R7");
        chk("R7 after 3 edges", {7'b0, irq}, 8'h01);
        // R8 hold then clear on status read
        repeat (4) step(0, 0, 8'h00, 3'b011, 1, 0, "R8");
        chk("R8 held", {7'b0, irq}, 8'h01);
        step(0, 0, 8'h00, 3'b011, 1, 1, "R8");
        chk("R8 cleared", {7'b0, irq}, 8'h00);
        // R7 falling edge raises nothing
        repeat (5) step(0, 0, 8'h00, 3'b011, 0, 0, "R7");
        chk("R7 fall no irq", {7'b0, irq}, 8'h00);
        // R8 status read coincident with a new rise
        step(0, 0, 8'h00, 3'b011, 1, 0, "R8");
        step(0, 0, 8'h00, 3'b011, 1, 0, "R8");
        step(0, 0, 8'h00, 3'b011, 1, 1, "R8");
        chk("R8 rise beats read", {7'b0, irq}, 8'h01);
        // R9 clearing enable drops irq at write edge
        step(1, 1, 8'h00, 3'b011, 1, 0, "R9");
        chk("R9 disable clears", {7'b0, irq}, 8'h00);
        // R9 edge while disabled is lost
        step(0, 0, 8'h00, 3'b011, 0, 0, "R9");
        step(0, 0, 8'h00, 3'b011, 0, 0, "R9");
        step(0, 0, 8'h00, 3'b011, 0, 0, "R9");
        step(0, 0, 8'h00, 3'b011, 1, 0, "R9");
        step(0, 0, 8'h00, 3'b011, 1, 0, "R9");
        step(0, 0, 8'h00, 3'b011, 1, 0, "R9");
        step(1, 1, 8'h10, 3'b011, 1, 0, "R9");
        repeat (3) step(0, 0, 8'h00, 3'b011, 1, 0, "R9");
        chk("R9 lost edge", {7'b0, irq}, 8'h00);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[2] & r[3], 8'($urandom), 3'(r[6:4]),
                 r[9] ^ r[10], (r[13:11] == 3'b000), "R7 random irq");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule